// File: doc/BRIEF.md
# Programmable Logic Cell with Carry Mode

This block is one tile of a reconfigurable fabric. Two 3-input lookup tables are each addressed by the low three logic inputs. A mode setting decides where their outputs go. In logic mode the fourth input chooses between the two tables, so the cell realises any 4-input Boolean function. In carry mode the two table outputs become the operands of a full adder. The adder takes a ripple carry from the neighbouring cell and passes its own carry onward. A second setting picks the cell output: either the combinational result or a D flip-flop that samples it.

Configuration is loaded serially. While the load enable is high, one bit enters per clock, most significant bit first, into an 18-bit chain. During that time the output is held low and the flip-flop keeps its value, so a half-loaded setting never shows up at the output. The cell has no state machine beyond the configuration chain and the output flip-flop. It has two operating conditions:
- **LOAD** is active whenever `cfg_en` is high.
- **RUN** is active otherwise.
- Each change between them takes effect at once, in the same cycle that `cfg_en` changes.

Top module: `clc_cell`

## Requirements
- R1: While `cfg_en` is high, each rising edge shifts `cfg_data` into bit 0 of an 18-bit chain, and the older bits move up by one. After 18 such edges, the first bit sent sits in bit 17. The chain has the following layout:
  - Bits 7:0 are table A, indexed by `lin[2:0]`.
  - Bits 15:8 are table B, indexed the same way.
  - Bit 16 is the mode: 0 is logic and 1 is carry.
  - Bit 17 is the output select: 0 is combinational and 1 is registered.
- R2: In logic mode with the combinational output, `cell_out` is bit `lin[3:0]` of the 16-bit value formed by table B (upper half) and table A (lower half).
- R3: In carry mode with the combinational output, `cell_out` = A[lin[2:0]] xor B[lin[2:0]] xor `carry_in`. In this mode `lin[3]` has no effect.
- R4: In carry mode, `carry_out` is the majority of A[lin[2:0]], B[lin[2:0]] and `carry_in`. In logic mode, `carry_out` is 0.
- R5: With the registered output selected, and `ce` high and `cfg_en` low at a rising edge, the flip-flop takes the combinational result of the current mode. With `ce` low, it holds its value.
- R6: While `cfg_en` is high, `cell_out` is 0, and the flip-flop holds its value whatever the state of `ce`.
- R7: A synchronous active-high `rst` clears the flip-flop and the whole chain. After reset, `cell_out` and `carry_out` are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| lin | input | 4 | Logic inputs; bits 2:0 address the tables, bit 3 selects the table in logic mode |
| carry_in | input | 1 | Ripple carry from the neighbouring cell |
| ce | input | 1 | Clock enable of the output flip-flop |
| cfg_en | input | 1 | Configuration shift enable (LOAD condition) |
| cfg_data | input | 1 | Serial configuration bit, most significant bit first |
| carry_out | output | 1 | Carry to the next cell |
| cell_out | output | 1 | Cell output |

## Verification
The combinational output and `carry_out` follow `lin` and `carry_in` within the same cycle. The bench therefore drives these inputs at a falling edge and samples one nanosecond later, before any rising edge. The registered output changes at the first rising edge where `ce` is high after the inputs are applied. Registered checks drive at a falling edge, wait for the next rising edge, and sample one nanosecond after it. A configuration takes effect after 18 enabled rising edges. Forced-low and hold checks are sampled in the middle of a load and right after it, before any enabled capture could alter the flip-flop.

// File: rtl/clc_pkg.sv
package clc_pkg;

    typedef enum logic {
        MODE_LOGIC = 1'b0,
        MODE_CARRY = 1'b1
    } clc_mode_e;

    typedef enum logic {
        OSEL_COMB = 1'b0,
        OSEL_REG  = 1'b1
    } clc_osel_e;

endpackage

// File: rtl/clc_cfg_chain.sv
module clc_cfg_chain #(
    parameter int CFG_W = 18
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             shift_en,
    input  logic             din,
    output logic [CFG_W-1:0] word
);
    always_ff @(posedge clk) begin
        if (rst) begin
            word <= '0;
        end else if (shift_en) begin
            word <= {word[CFG_W-2:0], din};
        end
    end
endmodule

// File: rtl/clc_lut.sv
module clc_lut #(
    parameter int K = 3,
    localparam int ENTRIES = 1 << K
) (
    input  logic [ENTRIES-1:0] table_bits,
    input  logic [K-1:0]       sel,
    output logic               y
);
    assign y = table_bits[sel];
endmodule

// File: rtl/clc_combine.sv
module clc_combine
    import clc_pkg::*;
(
    input  clc_mode_e mode,
    input  logic      lut_a,
    input  logic      lut_b,
    input  logic      sel_hi,
    input  logic      cin,
    output logic      res,
    output logic      cout
);
    always_comb begin
        unique case (mode)
            MODE_LOGIC: begin
                res  = sel_hi ? lut_b : lut_a;
                cout = 1'b0;
            end
            MODE_CARRY: begin
                res  = lut_a ^ lut_b ^ cin;
                cout = (lut_a & lut_b) | (lut_a & cin) | (lut_b & cin);
            end
            default: begin
                res  = 1'b0;
                cout = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/clc_cell.sv
module clc_cell
    import clc_pkg::*;
#(
    parameter int LUT_K = 3,
    localparam int LUT_BITS = 1 << LUT_K,
    localparam int IN_W = LUT_K + 1,
    localparam int CFG_W = 2 * LUT_BITS + 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [IN_W-1:0] lin,
    input  logic            carry_in,
    input  logic            ce,
    input  logic            cfg_en,
    input  logic            cfg_data,
    output logic            carry_out,
    output logic            cell_out
);
    logic [CFG_W-1:0] cfg_word;
    logic [1:0]       lut_y;
    clc_mode_e        cur_mode;
    clc_osel_e        cur_osel;
    logic             comb_res;
    logic             ff_q;

    clc_cfg_chain #(.CFG_W(CFG_W)) u_chain (
        .clk      (clk),
        .rst      (rst),
        .shift_en (cfg_en),
        .din      (cfg_data),
        .word     (cfg_word)
    );

    for (genvar g = 0; g < 2; g++) begin : g_lut
        clc_lut #(.K(LUT_K)) u_lut (
            .table_bits (cfg_word[g*LUT_BITS +: LUT_BITS]),
            .sel        (lin[LUT_K-1:0]),
            .y          (lut_y[g])
        );
    end

    assign cur_mode = clc_mode_e'(cfg_word[CFG_W-2]);
    assign cur_osel = clc_osel_e'(cfg_word[CFG_W-1]);

    clc_combine u_comb (
        .mode   (cur_mode),
        .lut_a  (lut_y[0]),
        .lut_b  (lut_y[1]),
        .sel_hi (lin[IN_W-1]),
        .cin    (carry_in),
        .res    (comb_res),
        .cout   (carry_out)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ff_q <= 1'b0;
        end else if (ce && !cfg_en) begin
            ff_q <= comb_res;
        end
    end

    always_comb begin
        if (cfg_en) begin
            cell_out = 1'b0;
        end else begin
            unique case (cur_osel)
                OSEL_COMB: cell_out = comb_res;
                OSEL_REG:  cell_out = ff_q;
                default:   cell_out = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/clc_cell_chk.sv
module clc_cell_chk (
    input logic clk,
    input logic rst,
    input logic cfg_en,
    input logic cfg_data,
    input logic ce,
    input logic cell_out,
    input logic carry_out,
    input logic ff_q,
    input logic comb_res,
    input logic cfg_lsb,
    input logic mode_bit
);
    // R1
    cfg_shift_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_en |=> (cfg_lsb == $past(cfg_data)));

    // R4
    logic_no_carry_chk: assert property (@(posedge clk) disable iff (rst)
        !mode_bit |-> !carry_out);

    // R5
    ff_capture_chk: assert property (@(posedge clk) disable iff (rst)
        (ce && !cfg_en) |=> (ff_q == $past(comb_res)));

    // R5
    ff_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!ce && !cfg_en) |=> $stable(ff_q));

    // R6
    load_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_en |-> !cell_out);

    // R6
    load_hold_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_en |=> $stable(ff_q));

    // R7
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!ff_q && !cfg_lsb && !mode_bit));
endmodule

bind clc_cell clc_cell_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_en    (cfg_en),
    .cfg_data  (cfg_data),
    .ce        (ce),
    .cell_out  (cell_out),
    .carry_out (carry_out),
    .ff_q      (ff_q),
    .comb_res  (comb_res),
    .cfg_lsb   (cfg_word[0]),
    .mode_bit  (cfg_word[CFG_W-2])
);

// File: tb/clc_cell_tb.sv
module clc_cell_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] lin = '0;
    logic       carry_in = 1'b0;
    logic       ce = 1'b0;
    logic       cfg_en = 1'b0;
    logic       cfg_data = 1'b0;
    logic       carry_out;
    logic       cell_out;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    clc_cell u_dut (
        .clk(clk), .rst(rst), .lin(lin), .carry_in(carry_in), .ce(ce),
        .cfg_en(cfg_en), .cfg_data(cfg_data), .carry_out(carry_out), .cell_out(cell_out)
    );

    function automatic logic ref_res(logic [17:0] c, logic [3:0] x, logic ci);
        logic a, b;
        a = c[x[2:0]];
        b = c[8 + x[2:0]];
        if (c[16]) return a ^ b ^ ci;
        return x[3] ? b : a;
    endfunction

    function automatic logic ref_cout(logic [17:0] c, logic [3:0] x, logic ci);
        logic a, b;
        a = c[x[2:0]];
        b = c[8 + x[2:0]];
        if (!c[16]) return 1'b0;
        return (a & b) | (a & ci) | (b & ci);
    endfunction

    task automatic check(logic got, logic exp, string req, string what);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0b expected %0b", req, what, got, exp);
        end
    endtask

    // R1: load 18 bits MSB first, with ce held high to exercise R6 hold
    task automatic load_cfg(logic [17:0] c, bit mid_check);
        @(negedge clk);
        cfg_en = 1'b1;
        ce = 1'b1;
        for (int i = 17; i >= 0; i--) begin
            cfg_data = c[i];
            @(negedge clk);
            if (mid_check && i == 9) check(cell_out, 1'b0, "R6", "output forced low mid-load");
        end
        cfg_en = 1'b0;
        ce = 1'b0;
        cfg_data = 1'b0;
    endtask

    task automatic sweep_comb(logic [17:0] c, string req);
        for (int ci = 0; ci < 2; ci++) begin
            for (int x = 0; x < 16; x++) begin
                @(negedge clk);
                lin = 4'(x);
                carry_in = 1'(ci);
                #1;
                check(cell_out, ref_res(c, 4'(x), 1'(ci)), req, "combinational result");
                check(carry_out, ref_cout(c, 4'(x), 1'(ci)), "R4", "carry out");
            end
        end
    endtask

    task automatic sweep_reg(logic [17:0] c);
        for (int k = 0; k < 24; k++) begin
            logic [3:0] x;
            logic ci;
            x = 4'($urandom_range(0, 15));
            ci = 1'($urandom_range(0, 1));
            @(negedge clk);
            lin = x;
            carry_in = ci;
            ce = 1'b1;
            @(posedge clk);
            #1;
            check(cell_out, ref_res(c, x, ci), "R5", "registered capture");
        end
        @(negedge clk);
        ce = 1'b0;
    endtask

    initial begin
        logic [17:0] c;
        logic        held;
        void'($urandom(32'd1234));

        // R7: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(cell_out, 1'b0, "R7", "output in reset");
        check(carry_out, 1'b0, "R7", "carry in reset");
        rst = 1'b0;

        // R2 directed: 4-input AND = only bit 15 set; R3 directed: sum with A=all ones, B=0
        c = {1'b0, 1'b0, 8'h80, 8'h00};
        load_cfg(c, 1'b0);
        sweep_comb(c, "R2");
        c = {1'b0, 1'b1, 8'h00, 8'hFF};
        load_cfg(c, 1'b0);
        sweep_comb(c, "R3");

        // Random configurations in both modes, combinational output
        for (int n = 0; n < 8; n++) begin
            c = 18'($urandom);
            c[17] = 1'b0;
            c[16] = 1'(n & 1);
            load_cfg(c, 1'b0);
            sweep_comb(c, c[16] ? "R3" : "R2");
        end

        // Registered output in both modes
        for (int n = 0; n < 4; n++) begin
            c = 18'($urandom);
            c[17] = 1'b1;
            c[16] = 1'(n & 1);
            load_cfg(c, 1'b0);
            sweep_reg(c);
        end

        // R5 hold with ce low: capture a 1, then change inputs without enable
        c = {1'b1, 1'b0, 8'h00, 8'hFF};
        load_cfg(c, 1'b0);
        @(negedge clk); lin = 4'h0; ce = 1'b1;
        @(negedge clk); ce = 1'b0; lin = 4'h8;
        repeat (3) @(negedge clk);
        check(cell_out, 1'b1, "R5", "hold with ce low");

        // R6: reload with ce high; output low mid-load, flip-flop keeps its 1
        c = {1'b1, 1'b0, 8'h00, 8'h00};
        held = 1'b1;
        lin = 4'h0;
        load_cfg(c, 1'b1);
        #1;
        check(cell_out, held, "R6", "flip-flop held across load");

        // R7: reset mid-run clears state and configuration
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        lin = 4'hF; carry_in = 1'b1;
        #1;
        check(cell_out, 1'b0, "R7", "output after reset");
        check(carry_out, 1'b0, "R7", "carry after reset");

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                n_tests++;
                n_fail++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule